// File: doc/BRIEF.md
# Polled Byte Input Port with Ready Flag

This block is a conditional-transfer input port for an external device that delivers one byte at a time. When the device raises its strobe, the block latches the byte into a holding register and sets an active-high ready flag. The strobe is brought into the CPU clock domain first, and the capture happens in that domain.

The CPU finds the port through a 3-to-8 decode of address lines 16..14. The decode is enabled only while the active-low memory select and the active-low read strobe are both asserted. The memory-select region starts at 0x1000_0000.

- Slot 0 (base + 0x0000) is the data port. It returns the held byte.
- Slot 1 (base + 0x4000) is the status port. It returns the ready flag on bit 7.

Software polls the status port until bit 7 is set, then reads the data port. The end of that data read clears the flag. A bus output enable tells the surrounding bus logic when the port is driving.

Top module: `polled_byte_port`

## Requirements
- R1: After reset the ready flag is 0, the holding register is 0x00 and the bus output enable is low.
- R2: A rising edge of `dev_stb` loads `dev_data` into the holding register and sets the flag. With the default two synchronizer stages, a status read held from the clock cycle in which the strobe rises still shows the flag clear after 2 rising clock edges and shows it set after the 3rd.
- R3: A status read (`cpu_ms_n`=0, `cpu_rd_n`=0, `cpu_addr[16:14]`=1) drives the ready flag on bit 7 and 0 on bits 6:0, with the output enable high.
- R4: A data read (`cpu_ms_n`=0, `cpu_rd_n`=0, `cpu_addr[16:14]`=0) drives the held byte on `cpu_rdata`, with the output enable high.
- R5: The output enable is high only when `cpu_ms_n` and `cpu_rd_n` are both low and `cpu_addr[16:14]` is 0 or 1. Otherwise the output enable is low and `cpu_rdata` is 0x00.
- R6: The flag clears on the first clock edge at which `cpu_rd_n` is high after a cycle in which the data port was selected. A status read never clears the flag.
- R7: If a strobe capture and a data-read clear fall on the same clock edge, the flag ends up set and the new byte is held.
- R8: Capture happens on the strobe edge, not its level. Changes to `dev_data` while `dev_stb` stays high do not alter the held byte, and do not set the flag again after it has been cleared.
- R9: Decoding is partial. Address bits outside 16..14 do not affect which port responds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_data | input | 8 | Byte presented by the external device |
| dev_stb | input | 1 | Device strobe, asynchronous; a rising edge delivers a byte |
| cpu_addr | input | 32 | CPU address bus |
| cpu_ms_n | input | 1 | Active-low memory-select strobe for this region |
| cpu_rd_n | input | 1 | Active-low read strobe |
| cpu_rdata | output | 8 | Read data; 0x00 when the port is not selected |
| cpu_rdata_oe | output | 1 | High while the port drives the data bus |

## Verification
The main poll-then-read sequence runs on a table of bytes that includes all-zeros, all-ones, a lone bit 7 and a lone bit 0. These show whether the status word and the data word are muxed and cleared independently of each other. The same table also varies the address bits outside the decoded field, which separates partial decoding from full decoding.

Directed cases cover the rest:
- a status read held across the synchronizer, which pins the capture latency to the exact edge;
- a strobe edge timed onto the read-clear edge, which tells set-wins priority from clear-wins;
- a strobe held high while its data changes, which tells edge capture from level capture;
- strobe combinations that must leave the bus idle.

// File: rtl/polled_byte_port.sv
module polled_byte_port #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 32,
  parameter int SEL_LSB     = 14,
  parameter int SEL_W       = 3,
  parameter int DATA_SLOT   = 0,
  parameter int STAT_SLOT   = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] dev_data,
  input  logic              dev_stb,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_ms_n,
  input  logic              cpu_rd_n,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_rdata_oe
);

  logic [SYNC_STAGES-1:0] stb_sync_q;
  logic                   stb_last_q;
  logic                   cap_pulse;
  logic [DATA_W-1:0]      hold_q;
  logic                   ready_q;
  logic                   rd_data_q;
  logic                   decode_en;
  logic [SEL_W-1:0]       slot;
  logic                   data_sel;
  logic                   stat_sel;
  logic                   clr_pulse;
  logic                   unused_addr;

  assign unused_addr = ^cpu_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stb_sync_q <= '0;
      stb_last_q <= 1'b0;
    end else begin
      stb_sync_q <= {stb_sync_q[SYNC_STAGES-2:0], dev_stb};
      stb_last_q <= stb_sync_q[SYNC_STAGES-1];
    end
  end

  assign cap_pulse = stb_sync_q[SYNC_STAGES-1] & ~stb_last_q;

  assign decode_en = ~cpu_ms_n & ~cpu_rd_n;
  assign slot      = cpu_addr[SEL_LSB +: SEL_W];
  assign data_sel  = decode_en && (slot == SEL_W'(DATA_SLOT));
  assign stat_sel  = decode_en && (slot == SEL_W'(STAT_SLOT));
  assign clr_pulse = rd_data_q & cpu_rd_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q    <= '0;
      ready_q   <= 1'b0;
      rd_data_q <= 1'b0;
    end else begin
      rd_data_q <= data_sel;
      if (cap_pulse) hold_q <= dev_data;
      if (cap_pulse)      ready_q <= 1'b1;
      else if (clr_pulse) ready_q <= 1'b0;
    end
  end

  assign cpu_rdata_oe = data_sel | stat_sel;
  assign cpu_rdata    = data_sel ? hold_q
                      : stat_sel ? {ready_q, {(DATA_W-1){1'b0}}}
                      : '0;

endmodule

module polled_byte_port_chk #(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 32,
  parameter int SEL_LSB   = 14,
  parameter int SEL_W     = 3,
  parameter int DATA_SLOT = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] dev_data,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_ms_n,
  input logic              cpu_rd_n,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              cpu_rdata_oe,
  input logic              cap_pulse,
  input logic              stat_sel,
  input logic              ready_q,
  input logic [DATA_W-1:0] hold_q
);

  logic unused_bits;
  assign unused_bits = ^cpu_addr;

  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_pulse |=> hold_q == $past(dev_data));

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_pulse |=> ready_q);

  p_flag_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_q) |-> $past(cap_pulse));

  p_edge_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_pulse |=> $stable(hold_q));

  p_status_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stat_sel |-> (cpu_rdata[DATA_W-1] == ready_q && cpu_rdata[DATA_W-2:0] == '0 && cpu_rdata_oe));

  p_idle_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rdata_oe |-> cpu_rdata == '0);

  p_read_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!cpu_ms_n && !cpu_rd_n && cpu_addr[SEL_LSB +: SEL_W] == SEL_W'(DATA_SLOT))
     && cpu_rd_n && !cap_pulse) |=> !ready_q);

endmodule

bind polled_byte_port polled_byte_port_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_LSB(SEL_LSB),
  .SEL_W(SEL_W), .DATA_SLOT(DATA_SLOT)
) u_chk (.*);

// File: tb/polled_byte_port_bench.sv
module polled_byte_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC       = 2;
  localparam logic [31:0] BASE = 32'h1000_0000;
  localparam logic [31:0] STAT_OFS = 32'h0000_4000;
  localparam logic [39:0] VEC [6] = '{
    {32'h0000_0000, 8'h00}, {32'h0000_3FFC, 8'hFF}, {32'h0F02_0000, 8'h80},
    {32'h0000_0001, 8'h01}, {32'h00FE_2A00, 8'hA5}, {32'h0FF8_0010, 8'h5A}};

  logic clk = 0, rst_n = 0;
  logic [7:0] dev_data = 0;
  logic dev_stb = 0;
  logic [31:0] cpu_addr = 0;
  logic cpu_ms_n = 1, cpu_rd_n = 1;
  logic [7:0] cpu_rdata;
  logic cpu_rdata_oe;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  polled_byte_port u_polled_byte_port (
    .clk(clk), .rst_n(rst_n), .dev_data(dev_data), .dev_stb(dev_stb),
    .cpu_addr(cpu_addr), .cpu_ms_n(cpu_ms_n), .cpu_rd_n(cpu_rd_n),
    .cpu_rdata(cpu_rdata), .cpu_rdata_oe(cpu_rdata_oe));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_read(input logic [31:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    cpu_addr = a; cpu_ms_n = 0; cpu_rd_n = 0;
    #1; d = cpu_rdata; oe = cpu_rdata_oe;
    @(negedge clk);
    cpu_ms_n = 1; cpu_rd_n = 1;
  endtask

  task automatic strobe(input logic [7:0] b);
    @(negedge clk);
    dev_data = b; dev_stb = 1;
    repeat (SYNC + 3) @(negedge clk);
    dev_stb = 0;
    repeat (SYNC + 2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic oe;
    repeat (3) @(negedge clk);
    #1 chk("R1 oe in reset", {31'b0, cpu_rdata_oe}, 0);
    rst_n = 1;
    bus_read(BASE + STAT_OFS, d, oe);
    chk("R1 status after reset", d, 8'h00);
    bus_read(BASE, d, oe);
    chk("R1 data after reset", d, 8'h00);
    chk("R4 oe on data read", {31'b0, oe}, 1);

    foreach (VEC[i]) begin
      logic [31:0] a = BASE | VEC[i][39:8];
      strobe(VEC[i][7:0]);
      bus_read(a | STAT_OFS, d, oe);
      chk("R3 status ready R9", d, 8'h80);
      chk("R3 oe on status", {31'b0, oe}, 1);
      bus_read(a | STAT_OFS, d, oe);
      chk("R6 status read keeps flag", d, 8'h80);
      bus_read(a, d, oe);
      chk("R4 data byte R9", d, VEC[i][7:0]);
      bus_read(a | STAT_OFS, d, oe);
      chk("R6 flag cleared", d, 8'h00);
    end

    @(negedge clk);
    dev_data = 8'h6E; dev_stb = 1;
    cpu_addr = BASE + STAT_OFS; cpu_ms_n = 0; cpu_rd_n = 0;
    repeat (SYNC) @(negedge clk);
    #1 chk("R2 flag not yet set", cpu_rdata, 8'h00);
    @(negedge clk);
    #1 chk("R2 flag set on time", cpu_rdata, 8'h80);
    cpu_ms_n = 1; cpu_rd_n = 1;
    repeat (3) @(negedge clk);
    dev_stb = 0;
    repeat (SYNC + 2) @(negedge clk);
    bus_read(BASE, d, oe);
    chk("R2 captured byte", d, 8'h6E);

    strobe(8'h11);
    @(negedge clk);
    dev_data = 8'h3C; dev_stb = 1;
    cpu_addr = BASE; cpu_ms_n = 0; cpu_rd_n = 0;
    repeat (SYNC) @(negedge clk);
    cpu_ms_n = 1; cpu_rd_n = 1;
    repeat (3) @(negedge clk);
    dev_stb = 0;
    repeat (SYNC + 2) @(negedge clk);
    bus_read(BASE + STAT_OFS, d, oe);
    chk("R7 set wins over clear", d, 8'h80);
    bus_read(BASE, d, oe);
    chk("R7 new byte held", d, 8'h3C);

    @(negedge clk);
    dev_data = 8'h21; dev_stb = 1;
    repeat (SYNC + 3) @(negedge clk);
    dev_data = 8'h99;
    repeat (4) @(negedge clk);
    bus_read(BASE, d, oe);
    chk("R8 level ignored", d, 8'h21);
    bus_read(BASE + STAT_OFS, d, oe);
    chk("R8 no second set", d, 8'h00);
    dev_stb = 0;
    repeat (SYNC + 2) @(negedge clk);

    strobe(8'h77);
    @(negedge clk);
    cpu_addr = BASE + STAT_OFS; cpu_ms_n = 0; cpu_rd_n = 1;
    #1 chk("R5 no read strobe", {23'b0, cpu_rdata_oe, cpu_rdata}, 0);
    @(negedge clk);
    cpu_ms_n = 1; cpu_rd_n = 0;
    #1 chk("R5 no select", {23'b0, cpu_rdata_oe, cpu_rdata}, 0);
    @(negedge clk);
    cpu_addr = BASE + 32'h0001_4000; cpu_ms_n = 0;
    #1 chk("R5 unused slot", {23'b0, cpu_rdata_oe, cpu_rdata}, 0);
    @(negedge clk);
    cpu_ms_n = 1; cpu_rd_n = 1;
    bus_read(BASE + STAT_OFS, d, oe);
    chk("R5 flag kept", d, 8'h80);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule